// File: doc/BRIEF.md
# Debug Test Access Port with Debug Control Register

This block is the serial debug port of a processor core. An external probe drives a four-wire JTAG link (TCK, TMS, TDI, TDO) plus an active-high test reset. A sixteen-state TAP controller tracks TMS, a 5-bit instruction register picks which data register sits between TDI and TDO, and every data register captures in Capture-DR, shifts LSB first toward TDO in Shift-DR and, where writable, takes its new value in Update-DR.

The data registers are a fixed identification word, a fixed implementation word, the address of the pending core access, a data word, the 32-bit debug control register, a 33-bit fast-data register (data word plus an access-complete flag) and a 96-bit chain of address, data and control in one scan. Every other instruction code uses a 1-bit bypass. The control register reports core status and carries the probe's requests. Several of its bits mean one thing when read and another when written: writing 0 acknowledges or completes, and writing 1 leaves the state as it is. Two instructions set or clear a sticky boot-mode flag that the core samples on its next reset.

All core-side inputs are taken to be synchronous to TCK. The test reset `trst` is synchronous and active high.

Top module: `dbg_tap_top`

## Requirements
- R1: `trst` or five TCK cycles with TMS at 1 put the controller into Test-Logic-Reset, and that state loads the identification instruction (code 0x01). A data scan straight after reset returns the identification word.
- R2: Capture-IR loads the pattern 5'b00001, so the first five bits shifted out of TDO in Shift-IR are 1,0,0,0,0. The new code takes effect in Update-IR.
- R3: Code 0x01 selects a 32-bit register that captures the parameter `IDCODE_VAL`, whose bit 0 is 1. Code 0x03 selects a 32-bit register that captures `IMPCODE_VAL`.
- R4: Code 0x0C, code 0x0D and every code outside {0x01, 0x03, 0x08, 0x09, 0x0A, 0x0B, 0x0E} select a 1-bit bypass register that captures 0, so TDI reaches TDO one shift later.
- R5: Code 0x08 selects a 32-bit register that captures `core_addr`. Update-DR does not write it, and a later scan still captures `core_addr`.
- R6: Code 0x09 selects a 32-bit register that captures `core_wdata`. Update-DR drives the shifted-in word onto `probe_data`.
- R7: Code 0x0A selects the 32-bit control register. Its read value is: bit 31 reset-seen flag, bits 30:29 `acc_size` (0 byte, 1 halfword, 2 word, 3 triple), bit 20 peripheral reset request, bit 19 `acc_write` (1 write, 0 read or fetch), bit 18 `acc_pending`, bit 16 processor reset request, bit 12 break request pending, bit 3 `core_in_debug`. Every other bit reads 0.
- R8: A TCK cycle with `core_rst_seen` high sets the reset-seen flag (bit 31). Writing 0 to bit 31 clears it, and writing 1 leaves it set. A set from the core wins over a clear in the same cycle.
- R9: An Update-DR of the control register with bit 18 written 0 while `acc_pending` is high gives a one-cycle `acc_done` pulse in the TCK cycle after Update-DR. Writing 1 gives no pulse.
- R10: Control bit 16 written in Update-DR drives `proc_rst_req`, and bit 20 drives `periph_rst_req`. Both read back their current value, and Test-Logic-Reset clears both.
- R11: Writing 1 to control bit 12 sets `dbg_brk_req`. Writing 0 has no effect. The request stays high until a cycle with `core_in_debug` high clears it.
- R12: Code 0x0E selects a 33-bit register. Bit 0 captures `acc_pending` and bits 32:1 capture `core_wdata`. Update-DR drives bits 32:1 onto `probe_data`, and bit 0 written 0 while `acc_pending` is high pulses `acc_done` as in R9.
- R13: Code 0x0B selects a 96-bit chain. Bits 31:0 are address, bits 63:32 are data and bits 95:64 are control, so the address leaves TDO first. Update-DR applies the data part as in R6 and the control part as in R8 to R11.
- R14: Update-IR with code 0x0C sets `boot_debug` and Update-IR with code 0x0D clears it. Other instructions leave it unchanged, and only `trst` resets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected shift register in a Shift state, else 0 |
| core_rst_seen | input | 1 | Core reported a reset this cycle |
| acc_pending | input | 1 | Core access waiting on the probe |
| acc_write | input | 1 | Pending access is a write |
| acc_size | input | 2 | Pending access size |
| core_in_debug | input | 1 | Core is in debug mode |
| core_addr | input | 32 | Address of the pending access |
| core_wdata | input | 32 | Data offered by the core |
| probe_data | output | 32 | Data word written by the probe |
| acc_done | output | 1 | One-cycle pulse: probe completes the pending access |
| proc_rst_req | output | 1 | Processor reset request |
| periph_rst_req | output | 1 | Peripheral reset request |
| dbg_brk_req | output | 1 | Debug interrupt request |
| boot_debug | output | 1 | Sticky boot-into-debug flag |

## Verification
The hardest conditions to reach from the ports are the asymmetric write cases of the control register. A completion pulse or a flag clear must follow a written 0 only when the matching status is actually set, and it must not follow a written 1. The bench first sets the status with core-side inputs (a one-cycle `core_rst_seen` pulse, `acc_pending` held high). It then scans control words that differ in one bit, and it reads the register back in the next scan to see what survived. The 96-bit chain is checked both ways in one scan: the three captured words come out in order while the written data and reset bit land on the outputs.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    localparam int WORD_W = 32;
    localparam int IR_W   = 5;
    localparam int ALL_W  = 3 * WORD_W;
    localparam int FAST_W = WORD_W + 1;
    localparam int LEN_W  = $clog2(ALL_W + 1);

    typedef logic [IR_W-1:0]  ir_code_t;
    typedef logic [LEN_W-1:0] dr_len_t;

    localparam ir_code_t OP_IDCODE = 5'h01;
    localparam ir_code_t OP_IMP    = 5'h03;
    localparam ir_code_t OP_ADDR   = 5'h08;
    localparam ir_code_t OP_DATA   = 5'h09;
    localparam ir_code_t OP_CTRL   = 5'h0A;
    localparam ir_code_t OP_ALL    = 5'h0B;
    localparam ir_code_t OP_DBOOT  = 5'h0C;
    localparam ir_code_t OP_NBOOT  = 5'h0D;
    localparam ir_code_t OP_FAST   = 5'h0E;
    localparam ir_code_t IR_CAPTURE = 5'b00001;

    // control register bit positions (the probe software decodes these)
    localparam int CB_ROCC   = 31;
    localparam int CB_PSZ_LO = 29;
    localparam int CB_PERRST = 20;
    localparam int CB_PRNW   = 19;
    localparam int CB_PRACC  = 18;
    localparam int CB_PRRST  = 16;
    localparam int CB_BRK    = 12;
    localparam int CB_DM     = 3;

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI,
        TS_SELDR, TS_CAPDR, TS_SHDR, TS_EX1DR, TS_PADR, TS_EX2DR, TS_UPDR,
        TS_SELIR, TS_CAPIR, TS_SHIR, TS_EX1IR, TS_PAIR, TS_EX2IR, TS_UPIR
    } tap_state_t;

    typedef enum logic [2:0] {
        SEL_BYP, SEL_ID, SEL_IMP, SEL_ADDR, SEL_DATA, SEL_CTRL, SEL_ALL, SEL_FAST
    } dr_sel_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic m);
        case (s)
            TS_TLR:   return m ? TS_TLR   : TS_RTI;
            TS_RTI:   return m ? TS_SELDR : TS_RTI;
            TS_SELDR: return m ? TS_SELIR : TS_CAPDR;
            TS_CAPDR: return m ? TS_EX1DR : TS_SHDR;
            TS_SHDR:  return m ? TS_EX1DR : TS_SHDR;
            TS_EX1DR: return m ? TS_UPDR  : TS_PADR;
            TS_PADR:  return m ? TS_EX2DR : TS_PADR;
            TS_EX2DR: return m ? TS_UPDR  : TS_SHDR;
            TS_UPDR:  return m ? TS_SELDR : TS_RTI;
            TS_SELIR: return m ? TS_TLR   : TS_CAPIR;
            TS_CAPIR: return m ? TS_EX1IR : TS_SHIR;
            TS_SHIR:  return m ? TS_EX1IR : TS_SHIR;
            TS_EX1IR: return m ? TS_UPIR  : TS_PAIR;
            TS_PAIR:  return m ? TS_EX2IR : TS_PAIR;
            TS_EX2IR: return m ? TS_UPIR  : TS_SHIR;
            default:  return m ? TS_SELDR : TS_RTI;
        endcase
    endfunction

    function automatic dr_sel_t ir_to_sel(ir_code_t c);
        case (c)
            OP_IDCODE: return SEL_ID;
            OP_IMP:    return SEL_IMP;
            OP_ADDR:   return SEL_ADDR;
            OP_DATA:   return SEL_DATA;
            OP_CTRL:   return SEL_CTRL;
            OP_ALL:    return SEL_ALL;
            OP_FAST:   return SEL_FAST;
            default:   return SEL_BYP;
        endcase
    endfunction

    function automatic dr_len_t sel_len(dr_sel_t s);
        case (s)
            SEL_BYP:  return dr_len_t'(1);
            SEL_ALL:  return dr_len_t'(ALL_W);
            SEL_FAST: return dr_len_t'(FAST_W);
            default:  return dr_len_t'(WORD_W);
        endcase
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (trst) state <= TS_TLR;
        else      state <= tap_next(state, tms);
    end

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL  = 32'h1AB5_C0DF,
    parameter logic [31:0] IMPCODE_VAL = 32'h2040_4000
)(
    input  logic              tck,
    input  logic              trst,
    input  tap_state_t        state,
    input  dr_sel_t           sel,
    input  logic              tdi,
    input  logic [WORD_W-1:0] core_addr,
    input  logic [WORD_W-1:0] core_wdata,
    input  logic [WORD_W-1:0] ctrl_rd,
    input  logic              acc_pending,
    output logic              dr_out,
    output logic [WORD_W-1:0] ctrl_wr,
    output logic [WORD_W-1:0] probe_data
);

    logic [ALL_W-1:0] sr, cap, nxt;
    dr_len_t          len;

    assign len = sel_len(sel);

    always_comb begin
        cap = '0;
        case (sel)
            SEL_ID:   cap[WORD_W-1:0] = IDCODE_VAL;
            SEL_IMP:  cap[WORD_W-1:0] = IMPCODE_VAL;
            SEL_ADDR: cap[WORD_W-1:0] = core_addr;
            SEL_DATA: cap[WORD_W-1:0] = core_wdata;
            SEL_CTRL: cap[WORD_W-1:0] = ctrl_rd;
            SEL_ALL:  cap = {ctrl_rd, core_wdata, core_addr};
            SEL_FAST: cap[FAST_W-1:0] = {core_wdata, acc_pending};
            default:  cap = '0;
        endcase
    end

    // the selected length decides where TDI enters
    always_comb begin
        nxt = sr >> 1;
        nxt[len - dr_len_t'(1)] = tdi;
    end

    always_ff @(posedge tck) begin
        if (trst)                 sr <= '0;
        else if (state == TS_CAPDR) sr <= cap;
        else if (state == TS_SHDR)  sr <= nxt;
    end

    always_ff @(posedge tck) begin
        if (trst) probe_data <= '0;
        else if (state == TS_UPDR) begin
            case (sel)
                SEL_DATA: probe_data <= sr[WORD_W-1:0];
                SEL_ALL:  probe_data <= sr[2*WORD_W-1:WORD_W];
                SEL_FAST: probe_data <= sr[FAST_W-1:1];
                default:  probe_data <= probe_data;
            endcase
        end
    end

    assign dr_out  = sr[0];
    assign ctrl_wr = (sel == SEL_ALL) ? sr[ALL_W-1:2*WORD_W] : sr[WORD_W-1:0];

endmodule

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
    import dbg_tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst,
    input  logic              tlr,
    input  logic              upd_ctrl,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              upd_fast,
    input  logic              fast_flag,
    input  logic              core_rst_seen,
    input  logic              acc_pending,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic              core_in_debug,
    output logic [WORD_W-1:0] rd_word,
    output logic              acc_done,
    output logic              proc_rst_req,
    output logic              periph_rst_req,
    output logic              dbg_brk_req,
    output logic              rocc
);

    logic wr_unused;
    assign wr_unused = ^wr_word;

    always_ff @(posedge tck) begin
        if (trst) begin
            rocc           <= 1'b0;
            proc_rst_req   <= 1'b0;
            periph_rst_req <= 1'b0;
            dbg_brk_req    <= 1'b0;
            acc_done       <= 1'b0;
        end else begin
            // a written 0 completes, a written 1 leaves the access pending
            acc_done <= acc_pending &&
                        ((upd_ctrl && !wr_word[CB_PRACC]) || (upd_fast && !fast_flag));
            if (core_rst_seen)                      rocc <= 1'b1;
            else if (upd_ctrl && !wr_word[CB_ROCC]) rocc <= 1'b0;
            if (tlr) begin
                proc_rst_req   <= 1'b0;
                periph_rst_req <= 1'b0;
                dbg_brk_req    <= 1'b0;
            end else begin
                if (upd_ctrl) begin
                    proc_rst_req   <= wr_word[CB_PRRST];
                    periph_rst_req <= wr_word[CB_PERRST];
                end
                if (upd_ctrl && wr_word[CB_BRK]) dbg_brk_req <= 1'b1;
                else if (core_in_debug)          dbg_brk_req <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_word                         = '0;
        rd_word[CB_ROCC]                = rocc;
        rd_word[CB_PSZ_LO+1:CB_PSZ_LO]  = acc_size;
        rd_word[CB_PERRST]              = periph_rst_req;
        rd_word[CB_PRNW]                = acc_write;
        rd_word[CB_PRACC]               = acc_pending;
        rd_word[CB_PRRST]               = proc_rst_req;
        rd_word[CB_BRK]                 = dbg_brk_req;
        rd_word[CB_DM]                  = core_in_debug;
    end

endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
    import dbg_tap_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL  = 32'h1AB5_C0DF,
    parameter logic [31:0] IMPCODE_VAL = 32'h2040_4000
)(
    input  logic        tck,
    input  logic        trst,
    input  logic        tms,
    input  logic        tdi,
    output logic        tdo,
    input  logic        core_rst_seen,
    input  logic        acc_pending,
    input  logic        acc_write,
    input  logic [1:0]  acc_size,
    input  logic        core_in_debug,
    input  logic [31:0] core_addr,
    input  logic [31:0] core_wdata,
    output logic [31:0] probe_data,
    output logic        acc_done,
    output logic        proc_rst_req,
    output logic        periph_rst_req,
    output logic        dbg_brk_req,
    output logic        boot_debug
);

    tap_state_t        tap_state;
    ir_code_t          ir_sr, ir_q;
    dr_sel_t           sel;
    logic              dr_out, rocc_q, upd_dr;
    logic [WORD_W-1:0] ctrl_rd, ctrl_wr;

    dbg_tap_fsm u_fsm (
        .tck(tck), .trst(trst), .tms(tms), .state(tap_state)
    );

    always_ff @(posedge tck) begin
        if (trst)                   ir_sr <= '0;
        else if (tap_state == TS_CAPIR) ir_sr <= IR_CAPTURE;
        else if (tap_state == TS_SHIR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (trst || tap_state == TS_TLR) ir_q <= OP_IDCODE;
        else if (tap_state == TS_UPIR)   ir_q <= ir_sr;
    end

    always_ff @(posedge tck) begin
        if (trst) boot_debug <= 1'b0;
        else if (tap_state == TS_UPIR) begin
            if (ir_sr == OP_DBOOT)      boot_debug <= 1'b1;
            else if (ir_sr == OP_NBOOT) boot_debug <= 1'b0;
        end
    end

    assign sel    = ir_to_sel(ir_q);
    assign upd_dr = (tap_state == TS_UPDR);

    dbg_tap_dr #(.IDCODE_VAL(IDCODE_VAL), .IMPCODE_VAL(IMPCODE_VAL)) u_dr (
        .tck(tck), .trst(trst), .state(tap_state), .sel(sel), .tdi(tdi),
        .core_addr(core_addr), .core_wdata(core_wdata), .ctrl_rd(ctrl_rd),
        .acc_pending(acc_pending), .dr_out(dr_out), .ctrl_wr(ctrl_wr),
        .probe_data(probe_data)
    );

    dbg_tap_ctrl u_ctrl (
        .tck(tck), .trst(trst), .tlr(tap_state == TS_TLR),
        .upd_ctrl(upd_dr && (sel == SEL_CTRL || sel == SEL_ALL)),
        .wr_word(ctrl_wr),
        .upd_fast(upd_dr && sel == SEL_FAST), .fast_flag(dr_out),
        .core_rst_seen(core_rst_seen), .acc_pending(acc_pending),
        .acc_write(acc_write), .acc_size(acc_size), .core_in_debug(core_in_debug),
        .rd_word(ctrl_rd), .acc_done(acc_done), .proc_rst_req(proc_rst_req),
        .periph_rst_req(periph_rst_req), .dbg_brk_req(dbg_brk_req), .rocc(rocc_q)
    );

    always_comb begin
        case (tap_state)
            TS_SHIR: tdo = ir_sr[0];
            TS_SHDR: tdo = dr_out;
            default: tdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
    import dbg_tap_pkg::*;
(
    input logic       tck,
    input logic       trst,
    input tap_state_t state,
    input ir_code_t   ir_q,
    input logic       acc_done,
    input logic       dbg_brk_req,
    input logic       boot_debug,
    input logic       proc_rst_req,
    input logic       core_in_debug,
    input logic       core_rst_seen,
    input logic       rocc
);

    p_ir_idcode_r1: assert property (@(posedge tck) disable iff (trst)
        (state == TS_TLR) |=> (ir_q == OP_IDCODE));

    p_rocc_set_r8: assert property (@(posedge tck) disable iff (trst)
        core_rst_seen |=> rocc);

    p_done_origin_r9: assert property (@(posedge tck) disable iff (trst)
        acc_done |-> $past(state == TS_UPDR));

    p_done_pulse_r9: assert property (@(posedge tck) disable iff (trst)
        acc_done |=> !acc_done);

    p_rst_hold_r10: assert property (@(posedge tck) disable iff (trst)
        (state != TS_UPDR && state != TS_TLR) |=> $stable(proc_rst_req));

    p_brk_clear_r11: assert property (@(posedge tck) disable iff (trst)
        (core_in_debug && state != TS_UPDR) |=> !dbg_brk_req);

    p_boot_hold_r14: assert property (@(posedge tck) disable iff (trst)
        (state != TS_UPIR) |=> $stable(boot_debug));

endmodule

bind dbg_tap_top dbg_tap_chk u_chk (
    .tck(tck), .trst(trst), .state(tap_state), .ir_q(ir_q),
    .acc_done(acc_done), .dbg_brk_req(dbg_brk_req), .boot_debug(boot_debug),
    .proc_rst_req(proc_rst_req), .core_in_debug(core_in_debug),
    .core_rst_seen(core_rst_seen), .rocc(rocc_q)
);

// File: tb/tb_dbg_tap_top.sv
module tb_dbg_tap_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID_C   = 32'h1AB5_C0DF;
    localparam logic [31:0] IMP_C  = 32'h2040_4000;
    localparam logic [31:0] ADDR_C = 32'h8000_1234;
    localparam logic [31:0] DATA_C = 32'h5566_7788;
    localparam logic [95:0] PAT    = 96'h0;
    localparam logic [47:0] SCANPAT = 48'h3C96_E1F0_A55A;
    localparam logic [31:0] KEEP   = (32'h1 << 31) | (32'h1 << 18);

    // code, scan length, expected capture (low 32 bits)
    localparam int NV = 10;
    localparam logic [47:0] VEC [NV] = '{
        {8'h01, 8'd32, ID_C},
        {8'h03, 8'd32, IMP_C},
        {8'h08, 8'd32, ADDR_C},
        {8'h09, 8'd32, DATA_C},
        {8'h0E, 8'd33, {DATA_C[30:0], 1'b0}},
        {8'h00, 8'd1,  32'h0},
        {8'h0F, 8'd1,  32'h0},
        {8'h1F, 8'd1,  32'h0},
        {8'h0C, 8'd1,  32'h0},
        {8'h0D, 8'd1,  32'h0}
    };

    logic        tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic        tdo;
    logic        core_rst_seen = 1'b0, acc_pending = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic        core_in_debug = 1'b0;
    logic [31:0] core_addr = ADDR_C, core_wdata = DATA_C;
    logic [31:0] probe_data;
    logic        acc_done, proc_rst_req, periph_rst_req, dbg_brk_req, boot_debug;

    int n_cmp = 0, n_bad = 0;

    dbg_tap_top dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .core_rst_seen(core_rst_seen), .acc_pending(acc_pending),
        .acc_write(acc_write), .acc_size(acc_size), .core_in_debug(core_in_debug),
        .core_addr(core_addr), .core_wdata(core_wdata), .probe_data(probe_data),
        .acc_done(acc_done), .proc_rst_req(proc_rst_req),
        .periph_rst_req(periph_rst_req), .dbg_brk_req(dbg_brk_req),
        .boot_debug(boot_debug)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
    endtask

    task automatic shift_ir(input logic [4:0] code, output logic [4:0] dout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge tck);
            dout[i] = tdo;
            tdi = code[i];
            tms = (i == 4);
        end
        step(1, 0); step(0, 0);
        @(negedge tck);
    endtask

    task automatic shift_dr(input int len, input logic [95:0] din,
                            output logic [95:0] dout, output logic done);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) begin
            @(negedge tck);
            dout[i] = tdo;
            tdi = din[i];
            tms = (i == len - 1);
        end
        step(1, 0); step(0, 0);
        @(negedge tck);
        done = acc_done;
    endtask

    function automatic logic [31:0] ctrl_exp(input logic rocc, input logic [1:0] sz,
        input logic wr, input logic pend, input logic perrst, input logic prrst,
        input logic brk, input logic dm);
        logic [31:0] v;
        v = '0;
        v[31] = rocc; v[30:29] = sz; v[20] = perrst; v[19] = wr;
        v[18] = pend; v[16] = prrst; v[12] = brk; v[3] = dm;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [4:0]  irq;
        logic [95:0] q;
        logic        dn;
        logic [31:0] mask;
        int          len;

        repeat (3) @(negedge tck);
        // reset state
        check("R1 reset tdo", {95'b0, tdo}, 96'h0);
        check("R10 reset outputs", {92'b0, proc_rst_req, periph_rst_req, dbg_brk_req, acc_done}, 96'h0);
        check("R14 reset boot flag", {95'b0, boot_debug}, 96'h0);
        check("R6 reset probe_data", {64'b0, probe_data}, 96'h0);
        trst = 1'b0;
        step(0, 0);
        @(negedge tck);

        // R1: identification selected straight after reset
        shift_dr(32, PAT, q, dn);
        check("R1 idcode after reset", q[31:0], ID_C);
        check("R3 idcode bit0", {95'b0, q[0]}, 96'h1);

        // R2: capture pattern
        shift_ir(5'h01, irq);
        check("R2 IR capture pattern", {91'b0, irq}, 96'h1);

        // table walk: capture value and path length
        for (int v = 0; v < NV; v++) begin
            len  = int'(VEC[v][39:32]);
            mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
            shift_ir(VEC[v][44:40], irq);
            shift_dr(48, {48'h0, SCANPAT}, q, dn);
            check($sformatf("R3/R4 capture code %h", VEC[v][44:40]),
                  {64'b0, q[31:0] & mask}, {64'b0, VEC[v][31:0] & mask});
            check($sformatf("R4 path length code %h", VEC[v][44:40]),
                  (q >> len) & 96'hFF, {88'b0, SCANPAT[7:0]});
        end

        // R14: boot flag set, sticky, cleared
        shift_ir(5'h0C, irq);
        check("R14 boot set", {95'b0, boot_debug}, 96'h1);
        shift_ir(5'h01, irq);
        check("R14 boot sticky", {95'b0, boot_debug}, 96'h1);
        shift_ir(5'h0D, irq);
        check("R14 boot clear", {95'b0, boot_debug}, 96'h0);

        // R1: five TMS ones return to Test-Logic-Reset
        shift_ir(5'h08, irq);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        @(negedge tck);
        shift_dr(32, PAT, q, dn);
        check("R1 TMS reset loads idcode", q[31:0], ID_C);

        // R6: data register write
        shift_ir(5'h09, irq);
        shift_dr(32, 96'hDEAD_BEEF, q, dn);
        check("R6 data capture", q[31:0], DATA_C);
        check("R6 probe_data update", {64'b0, probe_data}, 96'hDEAD_BEEF);

        // R5: address not writable
        shift_ir(5'h08, irq);
        shift_dr(32, 96'h1234_5678, q, dn);
        shift_dr(32, 96'h0, q, dn);
        check("R5 address still captures core_addr", q[31:0], ADDR_C);
        check("R5 probe_data untouched", {64'b0, probe_data}, 96'hDEAD_BEEF);

        // R7/R8/R9: control register status
        @(negedge tck); core_rst_seen = 1'b1;
        @(negedge tck); core_rst_seen = 1'b0;
        acc_pending = 1'b1; acc_write = 1'b1; acc_size = 2'd2; core_in_debug = 1'b1;
        shift_ir(5'h0A, irq);
        shift_dr(32, {64'b0, KEEP}, q, dn);
        check("R7 control read fields", q[31:0], ctrl_exp(1, 2'd2, 1, 1, 0, 0, 0, 1));
        check("R9 write 1 no completion", {95'b0, dn}, 96'h0);
        shift_dr(32, {64'b0, 32'h8000_0000}, q, dn);
        check("R9 write 0 completes", {95'b0, dn}, 96'h1);
        shift_dr(32, {64'b0, 32'h0004_0000}, q, dn);
        check("R8 write 1 keeps reset flag", {95'b0, q[31]}, 96'h1);
        shift_dr(32, {64'b0, KEEP}, q, dn);
        check("R8 write 0 clears reset flag", {95'b0, q[31]}, 96'h0);

        // R10: reset requests
        core_in_debug = 1'b0;
        shift_dr(32, {64'b0, KEEP | 32'h0001_0000}, q, dn);
        check("R10 proc reset set", {94'b0, proc_rst_req, periph_rst_req}, 96'h2);
        shift_dr(32, {64'b0, KEEP | 32'h0010_0000}, q, dn);
        check("R10 proc reset reads back", q[31:0], ctrl_exp(0, 2'd2, 1, 1, 0, 1, 0, 0));
        check("R10 periph reset set", {94'b0, proc_rst_req, periph_rst_req}, 96'h1);
        shift_dr(32, {64'b0, KEEP}, q, dn);
        check("R10 periph reset reads back", q[31:0], ctrl_exp(0, 2'd2, 1, 1, 1, 0, 0, 0));
        check("R10 both released", {94'b0, proc_rst_req, periph_rst_req}, 96'h0);

        // R11: break request
        shift_dr(32, {64'b0, KEEP | 32'h0000_1000}, q, dn);
        check("R11 break set", {95'b0, dbg_brk_req}, 96'h1);
        shift_dr(32, {64'b0, KEEP}, q, dn);
        check("R11 break pending reads 1", {95'b0, q[12]}, 96'h1);
        check("R11 write 0 no effect", {95'b0, dbg_brk_req}, 96'h1);
        @(negedge tck); core_in_debug = 1'b1;
        @(negedge tck); core_in_debug = 1'b0;
        @(negedge tck);
        check("R11 cleared by debug entry", {95'b0, dbg_brk_req}, 96'h0);

        // R12: fast data
        core_wdata = 32'h0F1E_2D3C;
        shift_ir(5'h0E, irq);
        shift_dr(33, {63'b0, 32'hCAFE_F00D, 1'b0}, q, dn);
        check("R12 fast capture", {63'b0, q[32:0]}, {63'b0, 32'h0F1E_2D3C, 1'b1});
        check("R12 flag 0 completes", {95'b0, dn}, 96'h1);
        check("R12 fast data update", {64'b0, probe_data}, 96'hCAFE_F00D);
        shift_dr(33, {63'b0, 32'h1357_9BDF, 1'b1}, q, dn);
        check("R12 flag 1 no completion", {95'b0, dn}, 96'h0);
        check("R12 fast data update 2", {64'b0, probe_data}, 96'h1357_9BDF);

        // R13: chained scan
        acc_pending = 1'b0; acc_write = 1'b0; acc_size = 2'd1;
        core_addr = 32'h4444_0001; core_wdata = 32'h7777_0002;
        shift_ir(5'h0B, irq);
        shift_dr(96, {KEEP | 32'h0001_0000, 32'h0BAD_C0DE, 32'hFFFF_0000}, q, dn);
        check("R13 chain address part", q[31:0], 32'h4444_0001);
        check("R13 chain data part", q[63:32], 32'h7777_0002);
        check("R13 chain control part", q[95:64], ctrl_exp(0, 2'd1, 0, 0, 0, 0, 0, 0));
        check("R13 chain data update", {64'b0, probe_data}, 96'h0BAD_C0DE);
        check("R13 chain control update", {95'b0, proc_rst_req}, 96'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule